// File: doc/BRIEF.md
# Two-Byte Accumulator Processor Core

This block is a compact 8-bit processor core. Code and data share a byte-wide view. It fetches fixed-length instructions from an internal 256-byte program store. Each instruction is an opcode byte at an even address followed by an operand byte at the next address. The core executes one instruction every two clocks. The first clock captures the opcode. The second clock presents the operand and commits the result.

The core has an accumulator, a carry flag and a data-address pointer. It has an internal 256-byte data RAM. Every ALU result lands in the accumulator and also in the RAM byte the pointer currently selects. RAM byte 0x00 continuously drives the parallel output, so a program drives the output by pointing at 0x00 and computing. The program store is filled through a simple write port, normally while reset is held.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, fetch phase, accumulator, carry, data pointer and every data RAM byte are cleared, so `out_port` reads 0x00.
- R2: A fetch phase captures the byte at the even address as opcode. The next phase takes the odd byte as operand and commits. After reset is released, instruction k (counting from 0) has its effect visible after clock edge 2k+2 and not before.
- R3: Opcodes without the accumulator modifier work as follows. OR (0x01), AND (0x02) and ADD (0x03) combine the selected RAM byte with the operand. NOT (0x00) inverts the operand.
- R4: The accumulator-modifier forms use the accumulator in place of the RAM byte: OR_a (0x05), AND_a (0x06) and ADD_a (0x07). NOT_a (0x04) inverts the accumulator.
- R5: ADD and ADD_a add the carry flag as carry-in and store the carry-out in it. No other operation changes the carry.
- R6: CC (0x10) clears the carry flag.
- R7: Every ALU result is written both to the accumulator and to the RAM byte at the data pointer. `out_port` always shows RAM byte 0x00.
- R8: SEL (0x08) loads the operand into the data pointer. Later ALU reads and writes use that RAM byte.
- R9: JMP (0x20) loads the operand into the program counter. A jump taken from address 0xFE wins over the increment that would wrap.
- R10: A jump to an odd address is not corrected. The byte there is executed as an opcode and the byte after it as its operand.
- R11: Without a jump, the program counter wraps from 0xFF to 0x00 and execution continues from 0x00.
- R12: Any opcode other than the eleven listed has no effect on the accumulator, carry, pointer, RAM or program flow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 8 | Program store write address |
| prog_data | input | 8 | Program store write data |
| out_port | output | 8 | Parallel output, mirror of data RAM byte 0x00 |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is the jump load and the program-counter increment: when the jump sits at 0xFE, the increment would wrap. A program jumps into 0xFE and jumps away from there. The run is judged correct only if the output later shows a value written at the jump target. The second pair is the ALU's RAM write and the output update. With the pointer at 0x00, a result must reach `out_port` at exactly edge 2k+2. The bench checks this by sampling on the edges just before and just after.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
package acc8_pkg;

    localparam int CPU_DW = 8;
    localparam int CPU_AW = 8;

    typedef logic [CPU_DW-1:0] byte_t;

    typedef enum logic [1:0] {
        ALU_NOT = 2'd0,
        ALU_OR  = 2'd1,
        ALU_AND = 2'd2,
        ALU_ADD = 2'd3
    } alu_op_e;

    localparam byte_t OPC_SEL = 8'h08;
    localparam byte_t OPC_CC  = 8'h10;
    localparam byte_t OPC_JMP = 8'h20;

    typedef struct packed {
        logic    alu_en;
        alu_op_e op;
        logic    use_acc;
        logic    sel;
        logic    cc;
        logic    jmp;
    } ctrl_t;

    typedef struct packed {
        byte_t res;
        logic  cout;
    } alu_out_t;

    // bits 1:0 op, bit 2 accumulator source, bits 3..5 single control flags
    function automatic ctrl_t decode_op(byte_t opc);
        ctrl_t c;
        c.alu_en  = (opc[7:3] == 5'd0);
        c.op      = alu_op_e'(opc[1:0]);
        c.use_acc = opc[2];
        c.sel     = (opc == OPC_SEL);
        c.cc      = (opc == OPC_CC);
        c.jmp     = (opc == OPC_JMP);
        return c;
    endfunction

    function automatic alu_out_t alu_eval(alu_op_e op, logic use_acc, byte_t acc,
                                          byte_t mem, byte_t arg, logic cin);
        alu_out_t        r;
        byte_t           lhs;
        logic [CPU_DW:0] sum;
        lhs    = use_acc ? acc : mem;
        sum    = {1'b0, lhs} + {1'b0, arg} + {{CPU_DW{1'b0}}, cin};
        r.cout = cin;
        unique case (op)
            ALU_NOT: r.res = use_acc ? ~acc : ~arg;
            ALU_OR:  r.res = lhs | arg;
            ALU_AND: r.res = lhs & arg;
            default: begin
                r.res  = sum[CPU_DW-1:0];
                r.cout = sum[CPU_DW];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acc8_decode.sv
`timescale 1ns/1ps
module acc8_decode
    import acc8_pkg::*;
(
    input  byte_t opcode,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl = decode_op(opcode);
        // at most one instruction class active; undefined codes select none (R12)
        p_onehot_class_r12: assert ($onehot0({ctrl.alu_en, ctrl.sel, ctrl.cc, ctrl.jmp}))
            else $error("decode drove several instruction classes");
    end

endmodule

// File: rtl/acc8_fetch.sv
`timescale 1ns/1ps
module acc8_fetch
    import acc8_pkg::*;
#(
    parameter int ADDR_W = CPU_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  byte_t             prog_data,
    input  logic              jump_req,
    input  byte_t             jump_target,
    output logic              phase,
    output byte_t             ir,
    output byte_t             bus
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t             prog_mem [DEPTH];
    logic [ADDR_W-1:0] pc_q;
    logic              phase_q;
    byte_t             ir_q;

    always_ff @(posedge clk) begin
        if (prog_we) prog_mem[prog_addr] <= prog_data;
    end

    assign bus = prog_mem[pc_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            phase_q <= 1'b0;
            ir_q    <= '0;
        end else if (!phase_q) begin
            ir_q    <= bus;
            pc_q    <= pc_q + 1'b1;
            phase_q <= 1'b1;
        end else begin
            phase_q <= 1'b0;
            pc_q    <= jump_req ? ADDR_W'(jump_target) : pc_q + 1'b1;
        end
    end

    assign phase = phase_q;
    assign ir    = ir_q;

    p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
        (!phase_q) |=> (pc_q == $past(pc_q) + 1'b1));

    p_pc_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        (phase_q && !jump_req && (pc_q == '1)) |=> (pc_q == '0));

    p_jump_load_r9: assert property (@(posedge clk) disable iff (rst)
        (phase_q && jump_req) |=> (pc_q == ADDR_W'($past(jump_target))));

    p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        phase_q |=> $stable(ir_q));

endmodule

// File: rtl/acc8_compute.sv
`timescale 1ns/1ps
module acc8_compute
    import acc8_pkg::*;
#(
    parameter int ADDR_W = CPU_AW
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  exec,
    input  ctrl_t ctrl,
    input  byte_t operand,
    output byte_t out_port
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t             ram [DEPTH];
    byte_t             acc_q;
    logic              carry_q;
    logic [ADDR_W-1:0] sel_q;
    byte_t             mem_rd;
    alu_out_t          alu;

    assign mem_rd = ram[sel_q];
    assign alu    = alu_eval(ctrl.op, ctrl.use_acc, acc_q, mem_rd, operand, carry_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            sel_q   <= '0;
            for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
        end else if (exec) begin
            if (ctrl.alu_en) begin
                acc_q      <= alu.res;
                ram[sel_q] <= alu.res;
                if (ctrl.op == ALU_ADD) carry_q <= alu.cout;
            end
            if (ctrl.sel) sel_q   <= ADDR_W'(operand);
            if (ctrl.cc)  carry_q <= 1'b0;
        end
    end

    assign out_port = ram[0];

    p_cc_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (exec && ctrl.cc) |=> !carry_q);

    p_sel_load_r8: assert property (@(posedge clk) disable iff (rst)
        (exec && ctrl.sel) |=> (sel_q == ADDR_W'($past(operand))));

    p_carry_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!exec || !(ctrl.cc || (ctrl.alu_en && ctrl.op == ALU_ADD))) |=> $stable(carry_q));

    p_noop_r12: assert property (@(posedge clk) disable iff (rst)
        (exec && !ctrl.alu_en && !ctrl.sel && !ctrl.cc)
        |=> ($stable(acc_q) && $stable(sel_q) && $stable(carry_q)));

endmodule

// File: rtl/acc8_core.sv
`timescale 1ns/1ps
module acc8_core
    import acc8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_we,
    input  logic [7:0] prog_addr,
    input  logic [7:0] prog_data,
    output logic [7:0] out_port
);

    logic  phase;
    byte_t ir;
    byte_t bus;
    ctrl_t ctrl;

    acc8_fetch #(.ADDR_W(CPU_AW)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .prog_we     (prog_we),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .jump_req    (ctrl.jmp),
        .jump_target (bus),
        .phase       (phase),
        .ir          (ir),
        .bus         (bus)
    );

    acc8_decode u_decode (
        .opcode (ir),
        .ctrl   (ctrl)
    );

    acc8_compute #(.ADDR_W(CPU_AW)) u_compute (
        .clk      (clk),
        .rst      (rst),
        .exec     (phase),
        .ctrl     (ctrl),
        .operand  (bus),
        .out_port (out_port)
    );

endmodule

// File: tb/acc8_core_tb.sv
`timescale 1ns/1ps
module acc8_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [7:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [7:0] out_port;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] img [256];

    always #4 clk = ~clk;

    acc8_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .out_port  (out_port)
    );

    // {opcode, initial value, operand, expected}
    localparam logic [31:0] VEC [9] = '{
        {8'h01, 8'h0F, 8'hF0, 8'hFF},   // R3 OR with RAM byte
        {8'h02, 8'h3C, 8'h0F, 8'h0C},   // R3 AND with RAM byte
        {8'h03, 8'h12, 8'h34, 8'h46},   // R3 ADD with RAM byte
        {8'h00, 8'h55, 8'h0F, 8'hF0},   // R3 NOT of operand
        {8'h05, 8'h81, 8'h18, 8'h99},   // R4 OR_a
        {8'h06, 8'hF0, 8'h3C, 8'h30},   // R4 AND_a
        {8'h07, 8'h80, 8'h90, 8'h10},   // R4 ADD_a
        {8'h04, 8'h5A, 8'h77, 8'hA5},   // R4 NOT_a
        {8'h03, 8'hFF, 8'h02, 8'h01}    // R3 ADD wraps
    };

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic clear_img();
        for (int a = 0; a < 256; a++) img[a] = 8'h00;
    endtask

    task automatic put(int addr, logic [7:0] opc, logic [7:0] arg);
        img[addr]              = opc;
        img[(addr + 1) % 256]  = arg;
    endtask

    // hold reset, write the whole image, release reset on a falling edge
    task automatic load_and_start();
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 256; a++) begin
            prog_we   = 1'b1;
            prog_addr = 8'(a);
            prog_data = img[a];
            @(negedge clk);
        end
        prog_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1 + R2: reset state and exact commit edge
        clear_img();
        put(0, 8'h08, 8'h00);
        put(2, 8'h06, 8'h00);
        put(4, 8'h05, 8'h5A);
        put(6, 8'h20, 8'h06);
        load_and_start();
        check("R1 out after reset", out_port, 8'h00);
        step(5);
        check("R2 before edge 6", out_port, 8'h00);
        step(1);
        check("R2 at edge 6", out_port, 8'h5A);
        rst = 1'b1;
        step(1);
        check("R1 reset mid-run clears RAM", out_port, 8'h00);

        // R3 R4 R7: vector table
        for (int i = 0; i < 9; i++) begin
            clear_img();
            put(0, 8'h10, 8'h00);
            put(2, 8'h08, 8'h00);
            put(4, 8'h06, 8'h00);
            put(6, 8'h05, VEC[i][23:16]);
            put(8, VEC[i][31:24], VEC[i][15:8]);
            put(10, 8'h20, 8'h0A);
            load_and_start();
            step(30);
            check($sformatf("R3/R4/R7 vector %0d", i), out_port, VEC[i][7:0]);
        end

        // R5: carry from ADD_a feeds the next add
        clear_img();
        put(0, 8'h08, 8'h00);
        put(2, 8'h06, 8'h00);
        put(4, 8'h05, 8'hFF);
        put(6, 8'h07, 8'h01);
        put(8, 8'h07, 8'h05);
        put(10, 8'h20, 8'h0A);
        load_and_start();
        step(30);
        check("R5 carry in", out_port, 8'h06);

        // R6: CC between the adds
        clear_img();
        put(0, 8'h08, 8'h00);
        put(2, 8'h06, 8'h00);
        put(4, 8'h05, 8'hFF);
        put(6, 8'h07, 8'h01);
        put(8, 8'h10, 8'h00);
        put(10, 8'h07, 8'h05);
        put(12, 8'h20, 8'h0C);
        load_and_start();
        step(30);
        check("R6 cleared carry", out_port, 8'h05);

        // R8: write byte 5, clear byte 0, read byte 5 back
        clear_img();
        put(0, 8'h08, 8'h05);
        put(2, 8'h06, 8'h00);
        put(4, 8'h05, 8'h21);
        put(6, 8'h08, 8'h00);
        put(8, 8'h06, 8'h00);
        put(10, 8'h08, 8'h05);
        put(12, 8'h01, 8'h00);
        put(14, 8'h08, 8'h00);
        put(16, 8'h05, 8'h00);
        put(18, 8'h20, 8'h12);
        load_and_start();
        step(10);
        check("R8 other byte leaves output", out_port, 8'h00);
        step(40);
        check("R8 read back selected byte", out_port, 8'h21);

        // R9: jump from 0xFE beats the wrap
        clear_img();
        put(0, 8'h20, 8'hFE);
        put(8'hFE, 8'h20, 8'h40);
        put(8'h40, 8'h08, 8'h00);
        put(8'h42, 8'h06, 8'h00);
        put(8'h44, 8'h05, 8'h77);
        put(8'h46, 8'h20, 8'h46);
        load_and_start();
        step(40);
        check("R9 jump at 0xFE", out_port, 8'h77);

        // R10: odd jump target runs the operand byte as opcode
        clear_img();
        put(0, 8'h08, 8'h00);
        put(2, 8'h06, 8'h00);
        put(4, 8'h20, 8'h07);
        img[7]  = 8'h05;
        img[8]  = 8'h3C;
        img[9]  = 8'h20;
        img[10] = 8'h09;
        load_and_start();
        step(40);
        check("R10 odd target", out_port, 8'h3C);

        // R11: wrap from 0xFF back to 0x00
        clear_img();
        put(0, 8'h20, 8'hFA);
        put(8'hFA, 8'h08, 8'h00);
        put(8'hFC, 8'h06, 8'h00);
        put(8'hFE, 8'h05, 8'h33);
        load_and_start();
        step(8);
        check("R11 before wrap", out_port, 8'h33);
        step(5);
        check("R11 after wrap, before clear", out_port, 8'h33);
        step(1);
        check("R11 rerun after wrap", out_port, 8'h00);

        // R12: undefined opcodes change nothing
        clear_img();
        put(0, 8'h08, 8'h00);
        put(2, 8'h06, 8'h00);
        put(4, 8'h05, 8'h44);
        put(6, 8'h09, 8'h03);
        put(8, 8'h18, 8'h00);
        put(10, 8'h80, 8'h13);
        put(12, 8'h21, 8'h00);
        put(14, 8'h06, 8'h0F);
        put(16, 8'h20, 8'h10);
        load_and_start();
        step(20);
        check("R12 undefined skipped", out_port, 8'h04);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule